// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one display line and repeats it line after line. It works in units of pixel clocks: a pixel-clock enable marks the system-clock cycles on which the line timing moves forward. Each line starts with a line-clock/horizontal-sync pulse. A back porch follows, then the active pixels, then a front porch, and after that the next sync pulse begins.

A single 32-bit control word holds four timing fields. Every field stores its count minus one. The active width is stored in units of 16 pixels, as (pixels/16) minus 1, which gives 16 to 1024 pixels. A plain register port writes the control word and reads it back. The sequencer works from a copy of the word. It takes that copy only when a new line begins, so a write never disturbs the line in progress.

The outputs are the sync level, an active-data enable, the index of the current active pixel and a one-cycle end-of-line strobe. The block moves no pixel data, so it has no valid/ready interface and applies no back-pressure. All pins are plain control and status levels, sampled on the rising clock edge.

Top module: `lcd_hline_gen`

## Requirements
- R1: Control word layout: back porch in bits 31:24, front porch in bits 23:16, sync width in bits 15:8, active count in bits 7:2. A write with `reg_wr_en` high updates `reg_rdata` after that clock edge.
- R2: Bits 1:0 of the control word ignore writes and always read as 0. After reset the whole word reads as 0.
- R3: `line_sync` is high for exactly (bits 15:8)+1 pixel clocks at the start of each line and is low at every other time. It is never high together with `data_en`.
- R4: The back porch lasts (bits 31:24)+1 pixel clocks. It starts when `line_sync` falls, and `data_en` stays low for its whole length.
- R5: `data_en` is high for exactly 16*((bits 7:2)+1) pixel clocks after the back porch. During that time `pix_idx` counts 0, 1, … up to the active count minus 1. At all other times `pix_idx` is 0.
- R6: The front porch lasts (bits 23:16)+1 pixel clocks after the last active pixel. `line_sync` rises when it ends.
- R7: `eol` is high only on the final front-porch pixel clock, and only in a cycle where `pix_en` is high.
- R8: Timing advances only on cycles with `pix_en` high. While `pix_en` is low, `line_sync`, `data_en` and `pix_idx` hold their values.
- R9: A word written during a line takes effect at the next sync phase. The current line keeps its old timing.
- R10: After reset the block is in the sync phase with its counter cleared. The first line is 1 sync, 1 back-porch, 16 active and 1 front-porch pixel clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; timing advances when high |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back |
| line_sync | output | 1 | Line clock / horizontal sync, high during sync phase |
| data_en | output | 1 | Active-data enable |
| pix_idx | output | 10 | Active pixel index, 0 outside active phase |
| eol | output | 1 | End-of-line strobe on final front-porch pixel clock |

## Verification
The hardest case to reach from the ports is a control-word change that lands in the middle of a line. The word must not affect the line already under way, but it must govern the very next one. The stimulus first waits for an end-of-line strobe, which marks a known line start. It then measures one whole line while a concurrent thread writes a different word partway through that line. It measures the following line against the new fields. Extreme porch widths, the 1024-pixel maximum and sparse pixel-clock enables run through the same phase-counting measurement.

// File: rtl/lcd_hline_pkg.sv
package lcd_hline_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int PPL_W     = 6;
  localparam int GRAN_LOG2 = 4;
  localparam int BP_LSB    = 24;
  localparam int FP_LSB    = 16;
  localparam int SW_LSB    = 8;
  localparam int PPL_LSB   = 2;
  localparam int IDX_W     = PPL_W + GRAN_LOG2;
  localparam int CNT_W     = (IDX_W > FIELD_W) ? IDX_W : FIELD_W;
  localparam logic [WORD_W-1:0] RSVD_MASK = WORD_W'((1 << PPL_LSB) - 1);

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_BP   = 2'd1,
    PH_ACT  = 2'd2,
    PH_FP   = 2'd3
  } phase_t;

  typedef struct packed {
    logic [FIELD_W-1:0] bp;
    logic [FIELD_W-1:0] fp;
    logic [FIELD_W-1:0] sw;
    logic [PPL_W-1:0]   ppl;
  } timing_t;
endpackage

// File: rtl/lcd_hline_regs.sv
module lcd_hline_regs
  import lcd_hline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output timing_t           cfg
);
  logic [WORD_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wdata & ~RSVD_MASK;
    end
  end

  assign rdata   = ctrl_q;
  assign cfg.bp  = ctrl_q[BP_LSB  +: FIELD_W];
  assign cfg.fp  = ctrl_q[FP_LSB  +: FIELD_W];
  assign cfg.sw  = ctrl_q[SW_LSB  +: FIELD_W];
  assign cfg.ppl = ctrl_q[PPL_LSB +: PPL_W];
endmodule

// File: rtl/lcd_hline_seq.sv
module lcd_hline_seq
  import lcd_hline_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  timing_t          cfg,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  timing_t          shadow_q;
  phase_t           phase_q;
  phase_t           phase_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // terminal count of the current phase, taken from the latched copy
  always_comb begin
    unique case (phase_q)
      PH_SYNC: limit = CNT_W'(shadow_q.sw);
      PH_BP:   limit = CNT_W'(shadow_q.bp);
      PH_ACT:  limit = CNT_W'({shadow_q.ppl, {GRAN_LOG2{1'b1}}});
      default: limit = CNT_W'(shadow_q.fp);
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_SYNC: phase_nx = PH_BP;
      PH_BP:   phase_nx = PH_ACT;
      PH_ACT:  phase_nx = PH_FP;
      default: phase_nx = PH_SYNC;
    endcase
  end

  assign last = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_SYNC;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (step) begin
      if (last) begin
        cnt_q   <= '0;
        phase_q <= phase_nx;
        if (phase_q == PH_FP) begin
          shadow_q <= cfg;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/lcd_hline_out.sv
module lcd_hline_out
  import lcd_hline_pkg::*;
(
  input  phase_t           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             last,
  input  logic             step,
  output logic             line_sync,
  output logic             data_en,
  output logic [IDX_W-1:0] pix_idx,
  output logic             eol
);
  assign line_sync = (phase == PH_SYNC);
  assign data_en   = (phase == PH_ACT);
  assign pix_idx   = data_en ? cnt[IDX_W-1:0] : '0;
  assign eol       = step && last && (phase == PH_FP);
endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
  import lcd_hline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              line_sync,
  output logic              data_en,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              eol
);
  timing_t          cfg;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             last;

  lcd_hline_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  lcd_hline_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pix_en),
    .cfg   (cfg),
    .phase (phase),
    .cnt   (cnt),
    .last  (last)
  );

  lcd_hline_out u_out (
    .phase     (phase),
    .cnt       (cnt),
    .last      (last),
    .step      (pix_en),
    .line_sync (line_sync),
    .data_en   (data_en),
    .pix_idx   (pix_idx),
    .eol       (eol)
  );
endmodule

// File: rtl/lcd_hline_chk.sv
module lcd_hline_chk
  import lcd_hline_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              reg_wr_en,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              line_sync,
  input logic              data_en,
  input logic [IDX_W-1:0]  pix_idx,
  input logic              eol
);
  // R1
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata == ($past(reg_wdata) & ~RSVD_MASK));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[PPL_LSB-1:0] == '0);

  // R3
  excl_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_sync && data_en));

  // R4
  sync_fall_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_sync) |-> !data_en);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && pix_en) |=> (!data_en || pix_idx == $past(pix_idx) + IDX_W'(1)));

  // R6
  eol_then_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> line_sync);

  // R7
  eol_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> (pix_en && !data_en && !line_sync));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(line_sync) && $stable(data_en) && $stable(pix_idx)));
endmodule

bind lcd_hline_gen lcd_hline_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_en    (pix_en),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .line_sync (line_sync),
  .data_en   (data_en),
  .pix_idx   (pix_idx),
  .eol       (eol)
);

// File: tb/lcd_hline_gen_tb.sv
`timescale 1ns/1ps
module lcd_hline_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        line_sync;
  logic        data_en;
  logic [9:0]  pix_idx;
  logic        eol;

  int n_vec = 0;
  int n_bad = 0;
  int period = 0;

  always #2.5 clk = ~clk;

  lcd_hline_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_sync (line_sync),
    .data_en   (data_en),
    .pix_idx   (pix_idx),
    .eol       (eol)
  );

  // word, pixel-enable period
  localparam logic [35:0] VECS [0:4] = '{
    {32'h02030100, 4'd1},
    {32'h00000004, 4'd3},
    {32'hFFFF0508, 4'd1},
    {32'h0701FFFC, 4'd1},
    {32'h0406020F, 4'd2}
  };

  initial begin : en_drv
    int div;
    div = 0;
    forever begin
      @(posedge clk);
      #0.5;
      if (period == 0) begin
        pix_en = 1'b0;
        div = 0;
      end else begin
        div = (div + 1 >= period) ? 0 : div + 1;
        pix_en = (div == 0);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(posedge clk);
    #0.5;
    reg_wr_en = 1'b1;
    reg_wdata = w;
    @(posedge clk);
    #0.5;
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_eol();
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(eol && pix_en) && guard < 50000);
    chk(guard < 50000, "R7", "eol wait timeout", guard, 0);
  endtask

  // measure one line starting at a line boundary
  task automatic measure(input logic [31:0] w, input string tag);
    int n_sync, n_bp, n_act, n_fp, guard;
    bit seen_gap, seen_act, order_bad, idx_bad, eol_bad;
    int e_sw, e_bp, e_act, e_fp;
    e_bp  = int'(w[31:24]) + 1;
    e_fp  = int'(w[23:16]) + 1;
    e_sw  = int'(w[15:8]) + 1;
    e_act = 16 * (int'(w[7:2]) + 1);
    n_sync = 0; n_bp = 0; n_act = 0; n_fp = 0; guard = 0;
    seen_gap = 0; seen_act = 0; order_bad = 0; idx_bad = 0; eol_bad = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (eol && !pix_en) eol_bad = 1;
      if (!data_en && pix_idx != 0) idx_bad = 1;
      if (pix_en) begin
        if (line_sync) begin
          if (seen_gap || seen_act) order_bad = 1;
          n_sync++;
        end else if (data_en) begin
          if (pix_idx != 10'(n_act)) idx_bad = 1;
          n_act++;
          seen_act = 1;
          seen_gap = 1;
        end else begin
          seen_gap = 1;
          if (seen_act) n_fp++;
          else n_bp++;
        end
        if (eol) begin
          if (!seen_act || line_sync || data_en) eol_bad = 1;
          break;
        end
      end
      if (guard > 50000) break;
    end
    $display("line %s: sync %0d bp %0d act %0d fp %0d", tag, n_sync, n_bp, n_act, n_fp);
    chk(n_sync == e_sw, "R3", {tag, " sync width"}, n_sync, e_sw);
    chk(!order_bad, "R3", {tag, " sync outside line start"}, order_bad, 0);
    chk(n_bp == e_bp, "R4", {tag, " back porch"}, n_bp, e_bp);
    chk(n_act == e_act, "R5", {tag, " active count"}, n_act, e_act);
    chk(!idx_bad, "R5", {tag, " pixel index"}, idx_bad, 0);
    chk(n_fp == e_fp, "R6", {tag, " front porch"}, n_fp, e_fp);
    chk(!eol_bad && guard <= 50000, "R7", {tag, " eol placement"}, eol_bad, 0);
  endtask

  initial begin : watchdog
    #950000;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    logic [31:0] snap;
    repeat (4) @(posedge clk);
    #0.5;
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R2 zero word
    chk(line_sync == 1'b1, "R10", "sync after reset", line_sync, 1);
    chk(data_en == 1'b0, "R10", "data_en after reset", data_en, 0);
    chk(pix_idx == 0, "R10", "pix_idx after reset", pix_idx, 0);
    chk(eol == 1'b0, "R10", "eol after reset", eol, 0);
    chk(reg_rdata == 0, "R2", "word after reset", reg_rdata, 0);
    period = 1;
    measure(32'h0, "R10 reset line");

    // R8 hold while pix_en low
    period = 0;
    @(negedge clk);
    snap = {20'(0), line_sync, data_en, pix_idx};
    repeat (10) @(negedge clk);
    chk({20'(0), line_sync, data_en, pix_idx} == snap, "R8", "outputs held without pix_en",
        {20'(0), line_sync, data_en, pix_idx}, snap);
    period = 1;
    wait_eol();

    // vector table: R1 layout, R2 reserved bits, R3..R8 via measure
    for (int i = 0; i < 5; i++) begin
      w = VECS[i][35:4];
      period = int'(VECS[i][3:0]);
      wr(w);
      @(negedge clk);
      chk(reg_rdata == (w & 32'hFFFFFFFC), "R1", "readback", reg_rdata, w & 32'hFFFFFFFC);
      chk(reg_rdata[1:0] == 2'b00, "R2", "reserved bits", reg_rdata[1:0], 0);
      wait_eol();
      measure(w & 32'hFFFFFFFC, $sformatf("vec%0d", i));
    end

    // R9 mid-line write: current line old, next line new
    w = VECS[4][35:4] & 32'hFFFFFFFC;
    fork
      measure(w, "R9 old line");
      begin
        repeat (20) @(posedge clk);
        wr(32'h01010210);
      end
    join
    measure(32'h01010210, "R9 new line");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule